// File: doc/BRIEF.md
# Multi-Mode Base Timer with Direction-Aware Reset

The block is a free-running base timer, `W` bits wide, that counts on cycles where the count-clock enable is high. It has three count modes. In up-only mode it always increments. In up/down mode a direction register, set by software, selects increment or decrement. In two-phase mode it follows a pair of quadrature inputs and takes its direction from their order. Wrapping past all-ones (upward) or past zero (downward) raises a one-clock interrupt pulse.

Three events can reset the timer: a software strobe, a compare match (a step that lands on a programmed value while compare-reset is enabled), and an external active-low pin that must stay low long enough to qualify. A reset does not always clear the count. In up/down mode, a reset while counting up turns the direction around and leaves the count as it is. In two-phase mode, a reset while counting down is absorbed and the count is kept. A pin-caused reset never raises the timer interrupt. It raises a separate pin flag instead.

Each event is latched as pending and takes effect on the next enabled count edge. On that edge the reset replaces any count step.

Top module: `base_timer_rst`

## Requirements
- R1: Mode 0 (up-only) increments by one on every enabled cycle, holds the direction flag at 0, and pulses `irq_o` for one clock when the count wraps from all-ones to zero.
- R2: Mode 1 (up/down) steps by +1 when the direction register is 0 and by -1 when it is 1. `dir_wr_i` loads `dir_i` into that register on any clock on which no reset is applied. A wrap in either direction pulses `irq_o`.
- R3: Mode 2 (two-phase) samples {`pha_i`,`phb_i`} on enabled cycles. The sequence 00→10→11→01→00 counts up and the reverse sequence counts down. No change, or a change of both bits at once, gives no step. The direction flag shows the last step (1 = down).
- R4: The count changes only on enabled cycles. A software strobe (on any clock), a compare match (a step whose new value equals `cmp_val_i` while `cmp_en_i` is 1), or a qualified pin event becomes pending. It is applied on the next enabled cycle, and on that cycle no count step happens.
- R5: In mode 0 (and the reserved mode 3, which behaves as mode 0), an applied reset loads zero and the direction stays up.
- R6: In mode 1, a reset applied while the direction is up sets the direction to down and keeps the count.
- R7: In mode 1, a reset applied while the direction is down loads zero and the direction stays down.
- R8: In mode 2, an applied reset leaves the direction unchanged. It loads zero when the direction is up and keeps the count when it is down.
- R9: `ext_rst_n_i` passes through a two-flop synchronizer. It is recognized once per low period, on the second consecutive enabled sample that is low after a high sample. A low period seen on only one enabled sample is ignored.
- R10: A reset whose only pending source is the pin does not raise `irq_o`. `pin_irq_o` pulses for one clock on the clock where the pin reset is applied.
- R11: `irq_o` pulses for one clock on the clock where a software or compare-match reset is applied.
- R12: While `rst_n` is low at a clock edge, the count, the direction flag, both interrupt outputs and all pending events are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en_i | input | 1 | Count-clock enable |
| mode_i | input | 2 | 0 up-only, 1 up/down, 2 two-phase, 3 as 0 |
| dir_wr_i | input | 1 | Direction register write strobe (mode 1) |
| dir_i | input | 1 | Direction to write, 1 = down |
| pha_i | input | 1 | Phase A, already synchronous |
| phb_i | input | 1 | Phase B, already synchronous |
| ext_rst_n_i | input | 1 | External active-low reset pin |
| sw_rst_i | input | 1 | Software reset strobe |
| cmp_en_i | input | 1 | Enables compare-match reset |
| cmp_val_i | input | W | Compare value |
| count_o | output | W | Timer count |
| dir_o | output | 1 | Direction flag, 1 = down |
| irq_o | output | 1 | Timer interrupt pulse |
| pin_irq_o | output | 1 | Pin reset flag pulse |

## Verification
The bench builds the timer with `W` = 8 and keeps the default two-stage synchronizer and two-sample pin qualification. With 8 bits, wraps in both directions, compare hits at several values, and reset reversals landing near the wrap points all come up within a few hundred enabled cycles. The bench runs random segments in every mode with varied reset rates. Its directed cases cover a one-sample pin glitch, a long pin pulse, and an up/down reversal.

// File: rtl/bt_pkg.sv
// Shared types for the base timer: count mode codes and pending reset flags.
package bt_pkg;
    typedef enum logic [1:0] {
        BT_UP   = 2'd0,
        BT_UPDN = 2'd1,
        BT_QUAD = 2'd2,
        BT_RSVD = 2'd3
    } bt_mode_e;

    typedef struct packed {
        logic sw;
        logic cmp;
        logic pin;
    } bt_pend_t;
endpackage

// File: rtl/bt_pin_filter.sv
// Synchronizes the active-low reset pin and qualifies it on count-enable
// samples. det_o fires once per low period, on the QUAL-th consecutive low
// sample that follows a high sample. Assumes QUAL >= 2 and SYNC >= 1.
module bt_pin_filter #(
    parameter int SYNC = 2,
    parameter int QUAL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic pin_n_i,
    output logic det_o
);
    logic [SYNC-1:0] sync_q;
    logic [QUAL-1:0] hist_q;
    logic            lvl;

    // Synchronizer chain, idle-high after reset.
    for (genvar g = 0; g < SYNC; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q[g] <= 1'b1;
            end else if (g == 0) begin
                sync_q[g] <= pin_n_i;
            end else begin
                sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign lvl   = sync_q[SYNC-1];
    assign det_o = en_i & ~lvl & hist_q[QUAL-1] & ~(|hist_q[QUAL-2:0]);

    // History of enabled samples, newest in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else if (en_i) begin
            hist_q <= {hist_q[QUAL-2:0], lvl};
        end
    end

    // R9
    det_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_o |=> !det_o);
endmodule

// File: rtl/bt_quad_dec.sv
// Two-phase decoder. Samples {a,b} on enabled cycles and reports a single
// step when the pair moves one position along 00-10-11-01. Assumes the
// phase inputs are already synchronous to clk.
module bt_quad_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic pha_i,
    input  logic phb_i,
    output logic step_o,
    output logic up_o
);
    logic [1:0] prev_q;
    logic [1:0] pos_now, pos_old, delta;

    // Position of a phase pair along the forward sequence.
    function automatic logic [1:0] pos_of(input logic [1:0] ab);
        return {ab[0], ab[1] ^ ab[0]};
    endfunction

    // Step and direction from the position difference.
    always_comb begin
        pos_now = pos_of({pha_i, phb_i});
        pos_old = pos_of(prev_q);
        delta   = pos_now - pos_old;
        step_o  = en_i & delta[0];
        up_o    = (delta == 2'd1);
    end

    // Remember the last enabled sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 2'b00;
        end else if (en_i) begin
            prev_q <= {pha_i, phb_i};
        end
    end

    // R3
    quad_step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> (prev_q != $past(prev_q)));
endmodule

// File: rtl/bt_count_core.sv
// Count register, direction register, pending reset sources and interrupt
// pulses. Resets are latched and applied on the next enabled cycle, where
// they replace the count step. Assumes mode_i is static outside rst_n.
module bt_count_core
    import bt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en_i,
    input  logic [1:0]   mode_i,
    input  logic         dir_wr_i,
    input  logic         dir_i,
    input  logic         sw_rst_i,
    input  logic         cmp_en_i,
    input  logic [W-1:0] cmp_val_i,
    input  logic         pin_det_i,
    input  logic         q_step_i,
    input  logic         q_up_i,
    output logic [W-1:0] count_o,
    output logic         dir_o,
    output logic         irq_o,
    output logic         pin_irq_o
);
    localparam logic [W-1:0] CNT_ZERO = '0;
    localparam logic [W-1:0] CNT_ONES = '1;

    bt_mode_e     mode;
    logic         is_up, is_updn, is_quad;
    bt_pend_t     pend_q, pend_d;
    logic [W-1:0] count_q, count_d, stepped, rst_val;
    logic         dir_q, dir_d, irq_q, irq_d, pin_irq_q, pin_irq_d;
    logic         apply, step_en, step_up, wrap, cmp_hit;

    assign mode    = bt_mode_e'(mode_i);
    assign is_quad = (mode == BT_QUAD);
    assign is_updn = (mode == BT_UPDN);
    assign is_up   = !is_quad && !is_updn;
    assign apply   = cnt_en_i & (pend_q.sw | pend_q.cmp | pend_q.pin);

    // Select step enable and direction for the active mode.
    always_comb begin
        step_en = is_quad ? q_step_i : cnt_en_i;
        step_up = is_up ? 1'b1 : (is_updn ? !dir_q : q_up_i);
        stepped = step_up ? count_q + 1'b1 : count_q - 1'b1;
        wrap    = step_en & (step_up ? (count_q == CNT_ONES) : (count_q == CNT_ZERO));
        cmp_hit = !apply & step_en & cmp_en_i & (stepped == cmp_val_i);
    end

    // Count value loaded by a reset, by mode and direction.
    always_comb begin
        if (is_updn) begin
            rst_val = dir_q ? CNT_ZERO : count_q;
        end else if (is_quad) begin
            rst_val = dir_q ? count_q : CNT_ZERO;
        end else begin
            rst_val = CNT_ZERO;
        end
    end

    // Next-state for count, direction, pending flags and pulses.
    always_comb begin
        count_d    = apply ? rst_val : (step_en ? stepped : count_q);
        pend_d.sw  = (pend_q.sw  & !apply) | sw_rst_i;
        pend_d.cmp = (pend_q.cmp & !apply) | cmp_hit;
        pend_d.pin = (pend_q.pin & !apply) | pin_det_i;
        irq_d      = (apply & (pend_q.sw | pend_q.cmp)) | (!apply & wrap);
        pin_irq_d  = apply & pend_q.pin;
        if (is_up) begin
            dir_d = 1'b0;
        end else if (is_updn) begin
            dir_d = apply ? 1'b1 : (dir_wr_i ? dir_i : dir_q);
        end else begin
            dir_d = (!apply && step_en) ? !step_up : dir_q;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= CNT_ZERO;
            dir_q     <= 1'b0;
            irq_q     <= 1'b0;
            pin_irq_q <= 1'b0;
            pend_q    <= '0;
        end else begin
            count_q   <= count_d;
            dir_q     <= dir_d;
            irq_q     <= irq_d;
            pin_irq_q <= pin_irq_d;
            pend_q    <= pend_d;
        end
    end

    assign count_o   = count_q;
    assign dir_o     = dir_q;
    assign irq_o     = irq_q;
    assign pin_irq_o = pin_irq_q;

    // R1
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_up && cnt_en_i && !apply) |=> (count_q == $past(count_q) + 1'b1) && !dir_q);
    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_i |=> (count_q == $past(count_q)));
    // R6
    updn_reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && is_updn && !dir_q) |=> dir_q && (count_q == $past(count_q)));
    // R7
    updn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && is_updn && dir_q) |=> dir_q && (count_q == CNT_ZERO));
    // R8
    quad_dir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && is_quad) |=> (dir_q == $past(dir_q)));
    // R10
    pin_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && pend_q.pin && !pend_q.sw && !pend_q.cmp) |=> !irq_q && pin_irq_q);
endmodule

// File: rtl/base_timer_rst.sv
// Base timer top: pin qualifier, two-phase decoder and count core.
// Assumes pha_i/phb_i are synchronous and mode_i changes only in reset.
module base_timer_rst #(
    parameter int W    = 16,
    parameter int SYNC = 2,
    parameter int QUAL = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en_i,
    input  logic [1:0]   mode_i,
    input  logic         dir_wr_i,
    input  logic         dir_i,
    input  logic         pha_i,
    input  logic         phb_i,
    input  logic         ext_rst_n_i,
    input  logic         sw_rst_i,
    input  logic         cmp_en_i,
    input  logic [W-1:0] cmp_val_i,
    output logic [W-1:0] count_o,
    output logic         dir_o,
    output logic         irq_o,
    output logic         pin_irq_o
);
    logic pin_det, q_step, q_up;

    bt_pin_filter #(.SYNC(SYNC), .QUAL(QUAL)) u_pin (
        .clk(clk), .rst_n(rst_n), .en_i(cnt_en_i),
        .pin_n_i(ext_rst_n_i), .det_o(pin_det)
    );

    bt_quad_dec u_quad (
        .clk(clk), .rst_n(rst_n), .en_i(cnt_en_i),
        .pha_i(pha_i), .phb_i(phb_i), .step_o(q_step), .up_o(q_up)
    );

    bt_count_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en_i), .mode_i(mode_i),
        .dir_wr_i(dir_wr_i), .dir_i(dir_i), .sw_rst_i(sw_rst_i),
        .cmp_en_i(cmp_en_i), .cmp_val_i(cmp_val_i), .pin_det_i(pin_det),
        .q_step_i(q_step), .q_up_i(q_up), .count_o(count_o), .dir_o(dir_o),
        .irq_o(irq_o), .pin_irq_o(pin_irq_o)
    );
endmodule

// File: tb/tb_base_timer_rst.sv
`timescale 1ns/1ps
module tb_base_timer_rst;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b0, dir_wr = 1'b0, dir_in = 1'b0, pha = 1'b0, phb = 1'b0;
    logic ext_n = 1'b1, sw_rst = 1'b0, cmp_en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [TW-1:0] cmp_val = '0;
    logic [TW-1:0] count;
    logic dir, irq, pin_irq;

    int total = 0, bad = 0, pin_seen = 0, irq_seen = 0, qpos = 0;
    bit done = 0;

    // Reference state.
    logic [TW-1:0] mcnt;
    logic mdir, mirq, mpirq, psw, pcmp, ppin, mp1, mp2, mh0, mh1;
    logic [1:0] mprev;
    string tc = "R12", ti = "R12", tp = "R12";

    always #2.5 clk = ~clk;

    base_timer_rst #(.W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en), .mode_i(mode),
        .dir_wr_i(dir_wr), .dir_i(dir_in), .pha_i(pha), .phb_i(phb),
        .ext_rst_n_i(ext_n), .sw_rst_i(sw_rst), .cmp_en_i(cmp_en),
        .cmp_val_i(cmp_val), .count_o(count), .dir_o(dir), .irq_o(irq),
        .pin_irq_o(pin_irq)
    );

    function automatic int gidx(input logic [1:0] ab);
        return {30'd0, ab[0], ab[1] ^ ab[0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference update for one clock edge, from the requirements.
    task automatic model_edge();
        logic det, apply, st_en, st_up, wrap, isq, isud, isup, qs, qu;
        logic [TW-1:0] stp;
        int d;
        if (!rst_n) begin
            mcnt = '0; mdir = 0; mirq = 0; mpirq = 0; psw = 0; pcmp = 0; ppin = 0;
            mp1 = 1; mp2 = 1; mh0 = 1; mh1 = 1; mprev = 2'b00;
            tc = "R12"; ti = "R12"; tp = "R12";
            return;
        end
        isq = (mode == 2'd2); isud = (mode == 2'd1); isup = !isq && !isud;
        det = cnt_en && !mp2 && !mh0 && mh1;
        if (cnt_en) begin mh1 = mh0; mh0 = mp2; end
        mp2 = mp1; mp1 = ext_n;
        qs = 0; qu = 0;
        if (cnt_en) begin
            d = (gidx({pha, phb}) - gidx(mprev)) & 3;
            qs = (d == 1) || (d == 3); qu = (d == 1);
            mprev = {pha, phb};
        end
        apply = cnt_en && (psw || pcmp || ppin);
        st_en = isq ? qs : cnt_en;
        st_up = isup ? 1'b1 : (isud ? !mdir : qu);
        stp = st_up ? mcnt + 1'b1 : mcnt - 1'b1;
        wrap = st_en && (st_up ? (mcnt == '1) : (mcnt == '0));
        mirq = 0; mpirq = 0;
        if (apply) begin
            if (isup) begin mcnt = '0; tc = "R5"; end
            else if (isud) begin
                if (!mdir) tc = "R6"; else begin mcnt = '0; tc = "R7"; end
                mdir = 1;
            end else begin
                if (!mdir) mcnt = '0;
                tc = "R8";
            end
            mirq = psw || pcmp; mpirq = ppin;
            ti = (ppin && !(psw || pcmp)) ? "R10" : "R11"; tp = "R10";
            psw = 0; pcmp = 0; ppin = 0;
        end else begin
            if (st_en) begin
                mcnt = stp; mirq = wrap;
                if (cmp_en && stp == cmp_val) pcmp = 1;
            end
            tc = !cnt_en ? "R4" : (isup ? "R1" : (isud ? "R2" : "R3")); ti = tc; tp = "R9";
            if (isud && dir_wr) mdir = dir_in;
            if (isq && st_en) mdir = !st_up;
        end
        if (isup) mdir = 0;
        if (sw_rst) psw = 1;
        if (det) ppin = 1;
    endtask

    // One clock: edge, reference update, compare away from the edge.
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(count == mcnt, tc, "count", count, mcnt);
        chk(dir == mdir, tc, "dir", dir, mdir);
        chk(irq == mirq, ti, "irq", irq, mirq);
        chk(pin_irq == mpirq, tp, "pin_irq", pin_irq, mpirq);
        pin_seen += pin_irq; irq_seen += irq;
    endtask

    task automatic restart(input logic [1:0] m, input bit ce, input logic [TW-1:0] cv);
        rst_n = 0; mode = m; cmp_en = ce; cmp_val = cv;
        cnt_en = 0; sw_rst = 0; dir_wr = 0; ext_n = 1; pha = 0; phb = 0; qpos = 0;
        cyc(); cyc();
        rst_n = 1;
    endtask

    // Random segment with given event rates in percent.
    task automatic seg(input int n, input int en_pct, input int sw_pct, input int pin_pct, input int dw_pct);
        for (int i = 0; i < n; i++) begin
            int r;
            cnt_en = ($urandom % 100) < en_pct;
            sw_rst = ($urandom % 100) < sw_pct;
            if (($urandom % 100) < pin_pct) ext_n = ~ext_n;
            dir_wr = ($urandom % 100) < dw_pct;
            dir_in = $urandom % 2;
            r = $urandom % 10;
            if (r < 4) qpos = (qpos + 1) & 3;
            else if (r < 8) qpos = (qpos + 3) & 3;
            else if (r == 9) qpos = (qpos + 2) & 3;
            pha = (qpos == 1) || (qpos == 2);
            phb = (qpos >= 2);
            cyc();
        end
        sw_rst = 0; dir_wr = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        restart(2'd0, 0, '0);
        // R12: reset state at the ports
        chk(count == 0 && dir == 0 && irq == 0 && pin_irq == 0, "R12", "reset state", count, 0);

        // R1: free run through several wraps
        seg(700, 100, 0, 0, 0);
        // R4 R5 R11: compare and software resets in up-only mode
        restart(2'd0, 1, 8'd200);
        seg(800, 75, 2, 0, 0);

        // R9: single-sample low pin pulse is rejected
        restart(2'd0, 0, '0);
        cnt_en = 1;
        for (int i = 0; i < 6; i++) cyc();
        pin_seen = 0; irq_seen = 0;
        ext_n = 0; cyc(); ext_n = 1;
        for (int i = 0; i < 10; i++) cyc();
        chk(pin_seen == 0, "R9", "short pin pulses", pin_seen, 0);
        // R10: long pin pulse resets without timer interrupt
        pin_seen = 0; irq_seen = 0;
        ext_n = 0;
        for (int i = 0; i < 5; i++) cyc();
        ext_n = 1;
        for (int i = 0; i < 6; i++) cyc();
        chk(pin_seen == 1, "R10", "pin pulses", pin_seen, 1);
        chk(irq_seen == 0, "R10", "irq pulses", irq_seen, 0);

        // R6: reversal in up/down mode while counting up
        restart(2'd1, 0, '0);
        cnt_en = 1;
        for (int i = 0; i < 5; i++) cyc();
        sw_rst = 1; cyc(); sw_rst = 0;
        cyc(); cyc();
        chk(dir == 1, "R6", "dir after reversal", dir, 1);
        chk(count == 8'd5, "R6", "count after reversal", count, 5);

        // R2 R6 R7: mixed up/down traffic
        restart(2'd1, 1, 8'd50);
        seg(2000, 75, 3, 3, 4);
        // R2: downward wraps
        restart(2'd1, 0, '0);
        dir_wr = 1; dir_in = 1; cyc(); dir_wr = 0;
        seg(600, 100, 0, 0, 0);

        // R3 R8: two-phase traffic
        restart(2'd2, 1, 8'd5);
        seg(3000, 75, 2, 3, 0);
        restart(2'd2, 0, '0);
        seg(1500, 90, 0, 0, 0);

        // R5: reserved mode behaves as up-only
        restart(2'd3, 1, 8'd30);
        seg(400, 75, 3, 3, 4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule